// File: doc/BRIEF.md
# Strobed Handshake Parallel Port

This block is an 8-bit bidirectional parallel port with a per-bit direction register, a write data register that feeds the pin drivers, and a separate input latch. The input latch records the pin levels whenever the strobe input shows its selected edge. A register bus provides access to the data register, the direction register, the control register and a status register holding the strobe flag. A second address reads the input latch, and a write to that address also writes the data register.

The port has four operating modes. Simple strobed input only captures data and raises the flag. Input handshake also drives a strobe output that announces readiness for the next byte. Output handshake drives the same strobe output to announce that new data has been written. The three-state output variant also lets the data register drive the pins whose direction bit is 0, but only while the strobe input is at its active level. The strobe flag clears through a two-step sequence. A status read that sees the flag set comes first. An access to the latch address then completes the clear.

Top module: `hsk_pport`

## Requirements
- R1: Synchronous active-low reset clears the data register, the direction register and the strobe flag. It sets the control register to 0x02 (falling active edge, mode 0, strobe output active-high), so `stb_out` is low after reset.
- R2: A bus write to address 0 or address 1 loads all 8 data bits, and `pin_out` always shows the data register. Outside mode 3, `pin_oe` equals the direction register (bit 1 = output), so data can be written before the drivers are enabled.
- R3: Reading address 0 returns, bit by bit, the data register where the direction bit is 1 and `pin_in` where it is 0. In mode 3 it returns the data register for every bit.
- R4: On every active strobe edge, in any mode, the input latch loads `pin_in`, and address 1 reads it back. Control bit 0 selects the edge: 1 = rising, 0 = falling. Reset does not change the input latch.
- R5: An active strobe edge sets the strobe flag, which is read at address 4, bit 0.
- R6: A read of address 4 while the flag is 1 arms the clear. A later read of address 1 (modes 0 and 1), or a later write to address 1 (modes 2 and 3), then clears the flag and disarms it. The flag never clears unless the clear is armed. An active edge takes priority over a clear in the same cycle, sets the flag and disarms the clear.
- R7: Control bit 1 sets the polarity of `stb_out`: 1 makes the pin equal to the internal acknowledge, 0 inverts it. Address 3 reads the control register back in bits 3:0.
- R8: In mode 1 (input handshake, control bits 3:2 = 01), the acknowledge is set in the cycle the flag clears and is cleared by an active strobe edge.
- R9: In mode 2 (output handshake, 10) and mode 3 (three-state output, 11), a write to address 1 sets the acknowledge and an active strobe edge clears it. The edge wins when both occur together. In mode 0 the acknowledge is held at 0.
- R10: In mode 3, `pin_oe` is the direction register ORed with all ones while `stb_in` equals control bit 0, which is its active level.
- R11: Writes to address 4 have no effect, and reads of addresses 5 to 7 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| pin_in | input | 8 | Sensed pin levels |
| pin_out | output | 8 | Pin driver values |
| pin_oe | output | 8 | Pin driver enables |
| stb_in | input | 1 | Strobe input |
| stb_out | output | 1 | Strobe output |

## Verification
A wrong edge register or a wrong control register shows up within one clock, as a missing or extra flag bit at address 4 and as a premature or missing change on `stb_out`. A wrong armed state is not visible on its own. It shows only at the next access to the latch address, which clears the flag when it should not or leaves it set when it should clear. The reference model therefore runs long random bus traffic that mixes status reads and latch accesses. Because the input latch is never reset, its read-back is compared only after the model has seen a capture.

// File: rtl/hsk_pkg.sv
// Shared register addresses and control layout for the strobed parallel port.
package hsk_pkg;
    localparam int ADDR_W = 3;
    localparam logic [ADDR_W-1:0] A_DATA  = 3'd0;
    localparam logic [ADDR_W-1:0] A_LATCH = 3'd1;
    localparam logic [ADDR_W-1:0] A_DIR   = 3'd2;
    localparam logic [ADDR_W-1:0] A_CTRL  = 3'd3;
    localparam logic [ADDR_W-1:0] A_STAT  = 3'd4;

    typedef enum logic [1:0] {
        MODE_STROBE  = 2'b00,
        MODE_IN_HS   = 2'b01,
        MODE_OUT_HS  = 2'b10,
        MODE_OUT_TRI = 2'b11
    } mode_t;

    typedef struct packed {
        mode_t mode;    // [3:2]
        logic  hi_pol;  // [1] strobe-out active high
        logic  rise;    // [0] rising edge is active
    } ctrl_t;

    localparam int    CTRL_W     = 4;
    localparam ctrl_t CTRL_RESET = '{mode: MODE_STROBE, hi_pol: 1'b1, rise: 1'b0};
endpackage

// File: rtl/hsk_strobe_edge.sv
// Detects the selected edge on the strobe input.
// Assumes stb_in is already synchronous to clk. The edge output is held low
// during reset, and the history register is loaded from the pin during reset
// so no false edge appears when reset ends.
module hsk_strobe_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic stb_in,
    input  logic rise,
    output logic act_edge,
    output logic stb_active
);
    logic stb_d;

    // Keep the previous strobe level.
    always_ff @(posedge clk) begin
        stb_d <= stb_in;
    end

    // Selected edge and active level.
    always_comb begin
        act_edge   = rst_n & (rise ? (stb_in & ~stb_d) : (~stb_in & stb_d));
        stb_active = (stb_in == rise);
    end
endmodule

// File: rtl/hsk_flag_ctrl.sv
// Strobe flag with its two-step clear, and the strobe-out acknowledge.
// Assumes one bus access per cycle. An edge takes priority over a clear.
module hsk_flag_ctrl
    import hsk_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  act_edge,
    input  mode_t mode,
    input  logic  stat_rd,
    input  logic  latch_rd,
    input  logic  latch_wr,
    output logic  flag_q,
    output logic  ack_q
);
    logic armed_q;
    logic clr;

    // Second step of the clear: a latch access whose kind depends on the mode.
    always_comb begin
        clr = armed_q & (mode[1] ? latch_wr : latch_rd);
    end

    // Flag, arm and acknowledge state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q  <= 1'b0;
            armed_q <= 1'b0;
            ack_q   <= 1'b0;
        end else begin
            if (act_edge) begin
                flag_q  <= 1'b1;
                armed_q <= 1'b0;
            end else if (clr) begin
                flag_q  <= 1'b0;
                armed_q <= 1'b0;
            end else if (stat_rd && flag_q) begin
                armed_q <= 1'b1;
            end

            if (mode == MODE_STROBE || act_edge)
                ack_q <= 1'b0;
            else if (mode == MODE_IN_HS && clr)
                ack_q <= 1'b1;
            else if (mode[1] && latch_wr)
                ack_q <= 1'b1;
        end
    end

    p_flag_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        act_edge |=> flag_q);
    p_flag_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !armed_q) |=> flag_q);
    p_ack_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        act_edge |=> !ack_q);
endmodule

// File: rtl/hsk_port_regs.sv
// Data, direction and input-latch registers with the pin drive and read view.
// Assumes pin_in is synchronous. The input latch has no reset.
module hsk_port_regs #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_data_en,
    input  logic             wr_dir_en,
    input  logic [WIDTH-1:0] wdata,
    input  logic             act_edge,
    input  logic [WIDTH-1:0] pin_in,
    input  logic             tri_mode,
    input  logic             stb_active,
    output logic [WIDTH-1:0] data_q,
    output logic [WIDTH-1:0] dir_q,
    output logic [WIDTH-1:0] latch_q,
    output logic [WIDTH-1:0] pin_out,
    output logic [WIDTH-1:0] pin_oe,
    output logic [WIDTH-1:0] port_view
);
    // Data and direction registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            dir_q  <= '0;
        end else begin
            if (wr_data_en) data_q <= wdata;
            if (wr_dir_en)  dir_q  <= wdata;
        end
    end

    // Input latch that captures the pins on the strobe edge and is never reset.
    always_ff @(posedge clk) begin
        if (act_edge) latch_q <= pin_in;
    end

    // Per-bit pin drive and read-back view.
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        always_comb begin
            pin_out[i]   = data_q[i];
            pin_oe[i]    = dir_q[i] | (tri_mode & stb_active);
            port_view[i] = (tri_mode | dir_q[i]) ? data_q[i] : pin_in[i];
        end
    end

    p_data_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_data_en |=> data_q == $past(wdata));
    p_latch_cap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        act_edge |=> latch_q == $past(pin_in));
endmodule

// File: rtl/hsk_pport.sv
// Strobed handshake parallel port top: bus decode, control register, read mux.
// Assumes one bus access per cycle and a combinational read path.
module hsk_pport
    import hsk_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WIDTH-1:0]  bus_wdata,
    output logic [WIDTH-1:0]  bus_rdata,
    input  logic [WIDTH-1:0]  pin_in,
    output logic [WIDTH-1:0]  pin_out,
    output logic [WIDTH-1:0]  pin_oe,
    input  logic              stb_in,
    output logic              stb_out
);
    ctrl_t            ctrl_q;
    logic             rd, wr;
    logic             act_edge, stb_active;
    logic             flag_q, ack_q;
    logic [WIDTH-1:0] data_q, dir_q, latch_q, port_view;

    // Bus access decode.
    always_comb begin
        rd = bus_sel & ~bus_wr;
        wr = bus_sel & bus_wr;
    end

    // Control register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_q <= CTRL_RESET;
        else if (wr && bus_addr == A_CTRL)
            ctrl_q <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
    end

    hsk_strobe_edge u_edge (
        .clk(clk), .rst_n(rst_n), .stb_in(stb_in), .rise(ctrl_q.rise),
        .act_edge(act_edge), .stb_active(stb_active)
    );

    hsk_flag_ctrl u_flag (
        .clk(clk), .rst_n(rst_n), .act_edge(act_edge), .mode(ctrl_q.mode),
        .stat_rd(rd && bus_addr == A_STAT),
        .latch_rd(rd && bus_addr == A_LATCH),
        .latch_wr(wr && bus_addr == A_LATCH),
        .flag_q(flag_q), .ack_q(ack_q)
    );

    hsk_port_regs #(.WIDTH(WIDTH)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_data_en(wr && (bus_addr == A_DATA || bus_addr == A_LATCH)),
        .wr_dir_en(wr && bus_addr == A_DIR),
        .wdata(bus_wdata), .act_edge(act_edge), .pin_in(pin_in),
        .tri_mode(ctrl_q.mode == MODE_OUT_TRI), .stb_active(stb_active),
        .data_q(data_q), .dir_q(dir_q), .latch_q(latch_q),
        .pin_out(pin_out), .pin_oe(pin_oe), .port_view(port_view)
    );

    // Register read mux and strobe-out polarity.
    always_comb begin
        case (bus_addr)
            A_DATA:  bus_rdata = port_view;
            A_LATCH: bus_rdata = latch_q;
            A_DIR:   bus_rdata = dir_q;
            A_CTRL:  bus_rdata = {{(WIDTH-CTRL_W){1'b0}}, ctrl_q};
            A_STAT:  bus_rdata = {{(WIDTH-1){1'b0}}, flag_q};
            default: bus_rdata = '0;
        endcase
        stb_out = ctrl_q.hi_pol ? ack_q : ~ack_q;
    end

    p_reset_ctrl_r1: assert property (@(posedge clk)
        !rst_n |=> (ctrl_q == CTRL_RESET && !stb_out));
    p_stat_nowrite_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && bus_addr == A_STAT) |=> $stable(ctrl_q));
endmodule

// File: tb/hsk_pport_test.sv
`timescale 1ns/1ps
module hsk_pport_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_sel = 1'b0, bus_wr = 1'b0;
    logic [2:0] bus_addr = 3'd0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic [7:0] pin_in = 8'h00;
    logic [7:0] pin_out, pin_oe;
    logic       stb_in = 1'b1;
    logic       stb_out;

    int compared = 0, mismatched = 0, cycles = 0;
    bit done = 0;

    hsk_pport uut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
        .stb_in(stb_in), .stb_out(stb_out)
    );

    always #2.5 clk = ~clk;

    // Behavioural reference state.
    logic [7:0] m_data, m_dir, m_latch;
    logic [3:0] m_ctrl;
    logic       m_flag, m_arm, m_ack, m_stb_d;
    bit         m_valid = 0, m_latch_known = 0;

    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            m_data = 0; m_dir = 0; m_ctrl = 4'h2; m_flag = 0; m_arm = 0;
            m_ack = 0; m_stb_d = stb_in; m_valid = 1;
        end else if (m_valid) begin
            bit ev, clr, statrd, outm;
            int mode;
            mode   = m_ctrl[3:2];
            outm   = (mode >= 2);
            ev     = m_ctrl[0] ? (stb_in && !m_stb_d) : (!stb_in && m_stb_d);
            clr    = m_arm && bus_sel && bus_addr == 1 && (outm ? bus_wr : !bus_wr);
            statrd = bus_sel && !bus_wr && bus_addr == 4 && m_flag;
            if (ev) begin m_latch = pin_in; m_latch_known = 1; end
            if (mode == 0 || ev) m_ack = 0;
            else if (mode == 1 && clr) m_ack = 1;
            else if (outm && bus_sel && bus_wr && bus_addr == 1) m_ack = 1;
            if (ev) begin m_flag = 1; m_arm = 0; end
            else if (clr) begin m_flag = 0; m_arm = 0; end
            else if (statrd) m_arm = 1;
            if (bus_sel && bus_wr) begin
                if (bus_addr == 0 || bus_addr == 1) m_data = bus_wdata;
                if (bus_addr == 2) m_dir = bus_wdata;
                if (bus_addr == 3) m_ctrl = bus_wdata[3:0];
            end
            m_stb_d = stb_in;
        end
    end

    function automatic string rtag(input logic [2:0] a);
        case (a)
            3'd0: return "R3";
            3'd1: return "R4";
            3'd2: return "R1";
            3'd3: return "R7";
            3'd4: return "R6";
            default: return "R11";
        endcase
    endfunction

    task automatic check(input string req, input string what,
                         input logic [7:0] act, input logic [7:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
        end
    endtask

    // Compare every output on each falling edge.
    always @(negedge clk) begin
        if (m_valid && rst_n) begin
            logic [7:0] e_rd, e_oe;
            bit tri_m;
            tri_m = (m_ctrl[3:2] == 2'b11);
            case (bus_addr)
                3'd0: e_rd = tri_m ? m_data : ((m_dir & m_data) | (~m_dir & pin_in));
                3'd1: e_rd = m_latch;
                3'd2: e_rd = m_dir;
                3'd3: e_rd = {4'h0, m_ctrl};
                3'd4: e_rd = {7'h0, m_flag};
                default: e_rd = 8'h00;
            endcase
            e_oe = m_dir | ((tri_m && (stb_in == m_ctrl[0])) ? 8'hFF : 8'h00);
            if (bus_addr != 3'd1 || m_latch_known)
                check(rtag(bus_addr), "rdata", bus_rdata, e_rd);
            check("R2", "pin_out", pin_out, m_data);
            check(tri_m ? "R10" : "R2", "pin_oe", pin_oe, e_oe);
            check(m_ctrl[3:2] == 2'b01 ? "R8" : "R9", "stb_out", {7'h0, stb_out},
                  {7'h0, m_ctrl[1] ? m_ack : ~m_ack});
        end
    end

    task automatic go(input bit s, input bit w, input logic [2:0] a, input logic [7:0] d);
        bus_sel = s; bus_wr = w; bus_addr = a; bus_wdata = d;
        @(negedge clk); #1;
    endtask
    task automatic idle(input logic [2:0] a);
        go(0, 0, a, 8'h00);
    endtask
    task automatic strobe_pulse(input logic [7:0] v);
        pin_in = v; stb_in = ~stb_in; idle(3'd4);
        stb_in = ~stb_in; idle(3'd4);
    endtask

    // Watchdog.
    always @(posedge clk) begin
        if (cycles > 100000 && !done) begin
            mismatched++; compared++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        repeat (3) idle(3'd0);
        rst_n = 1'b1;
        // R1: reset values of direction, control, status and stb_out.
        idle(3'd2); idle(3'd3); idle(3'd4);
        // R2/R3: preload data, then enable drivers for the low nibble.
        pin_in = 8'h3C;
        go(1, 1, 3'd0, 8'hA5); idle(3'd0);
        go(1, 1, 3'd2, 8'h0F); idle(3'd0);
        // R7: polarity low then back to high.
        go(1, 1, 3'd3, 4'h0); idle(3'd3);
        go(1, 1, 3'd3, 4'h2); idle(3'd3);
        // R4/R5: falling edge capture in mode 0.
        stb_in = 1'b1; idle(3'd4);
        strobe_pulse(8'h5A); idle(3'd1);
        // R6: latch read without armed clear keeps the flag.
        go(1, 0, 3'd1, 0); idle(3'd4);
        go(1, 0, 3'd4, 0); go(1, 0, 3'd1, 0); idle(3'd4);
        // R4: rising edge select.
        go(1, 1, 3'd3, 4'h3); stb_in = 1'b0; idle(3'd4);
        strobe_pulse(8'hC3); idle(3'd1);
        // R8: input handshake.
        go(1, 1, 3'd3, 4'h7);
        go(1, 0, 3'd4, 0); go(1, 0, 3'd1, 0); idle(3'd4);
        strobe_pulse(8'h81); idle(3'd4);
        // R9: output handshake, write to latch address raises ack then clears flag.
        go(1, 1, 3'd3, 4'hB); go(1, 1, 3'd1, 8'h66); idle(3'd0);
        strobe_pulse(8'h12);
        go(1, 0, 3'd4, 0); go(1, 1, 3'd1, 8'h77); idle(3'd4);
        // R10: three-state variant with strobe active and inactive.
        go(1, 1, 3'd2, 8'h03); go(1, 1, 3'd3, 4'hF);
        stb_in = 1'b1; idle(3'd0); stb_in = 1'b0; idle(3'd0);
        // R11: status write ignored, unmapped reads zero.
        go(1, 1, 3'd4, 8'hFF); idle(3'd4); idle(3'd5); idle(3'd7);
        // R4: mid-run reset keeps the latch contents.
        rst_n = 1'b0; idle(3'd1); rst_n = 1'b1; idle(3'd1);
        // Mixed random traffic across all modes.
        for (int i = 0; i < 3000; i++) begin
            pin_in = 8'($urandom);
            if ($urandom_range(3) == 0) stb_in = ~stb_in;
            go(1'($urandom_range(1)), 1'($urandom_range(3) == 0),
               3'($urandom_range(5)), 8'($urandom));
        end
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule